// File: doc/BRIEF.md
# Latched Eight-Key Input Port

This block is a keyboard peripheral on a byte-wide I/O port. Eight key inputs feed a one-byte state register. A key press sets its bit, and the bit stays set, so a press shorter than the CPU's polling interval is not lost. When the CPU reads the port at the block's device number, the block returns the collected byte on the next cycle and starts collecting again from zero. The block does not take data in. A write strobe addressed to it changes nothing.

A small controller has two states. `ST_IDLE` means no read result is pending. `ST_DELIVER` means the cycle right after an accepted read, when the captured byte is on the output. The transition `ST_IDLE -> ST_DELIVER` fires on an accepted read. `ST_DELIVER -> ST_DELIVER` fires on a back-to-back accepted read. `ST_DELIVER -> ST_IDLE` and `ST_IDLE -> ST_IDLE` fire in any cycle with no accepted read. An accepted read is a read strobe whose port index equals the parameter `DEV_ID`.

Top module: `keypad_port`

## Requirements
- R1: After reset the state byte is 0x00, `rd_data_o` is 0x00 and the controller is in `ST_IDLE`. A first read after reset returns 0x00.
- R2: A key input high at a rising edge sets its state bit. The bit stays set in later cycles until an accepted read clears it.
- R3: An accepted read at rising edge N puts the state byte held before edge N on `rd_data_o` during the cycle after edge N, and clears the state.
- R4: A key that is high at the same edge as an accepted read is not included in that read. It is still set after the clear and appears in the next read.
- R5: A read strobe whose `port_sel_i` is not `DEV_ID` neither clears the state nor drives `rd_data_o`.
- R6: A write strobe, with or without a matching port index, has no effect on the state or on `rd_data_o`.
- R7: The bits are assigned as follows: bit 0 up, bit 1 down, bit 2 left, bit 3 right, bit 4 space, bit 5 'r', bit 6 '+', bit 7 '-'. Each key input bit maps to the same output bit.
- R8: `rd_data_o` is 0x00 in every cycle that does not directly follow an accepted read. Back-to-back accepted reads each return the keys collected since the previous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_i | input | 8 | Key pressed levels, one bit per key (R7 map) |
| port_sel_i | input | 8 | I/O port index of the current access |
| rd_stb_i | input | 1 | Read request strobe |
| wr_stb_i | input | 1 | Write request strobe (ignored) |
| rd_data_o | output | 8 | Read result, valid the cycle after an accepted read, else 0 |

## Verification
The assertions assume that the key inputs are already debounced levels that are stable around the rising edge. They also assume that the read strobe is a single-cycle sample, so that a strobe held for two cycles counts as two reads. The bench drives every input on the falling edge and raises each strobe for exactly one cycle. It holds a key for whole cycles, which matches what the properties take for granted.

// File: rtl/ksp_pkg.sv
package ksp_pkg;
    localparam int KEY_W = 8;

    // Bit positions of the keys in the state byte
    localparam int KEY_UP    = 0;
    localparam int KEY_DOWN  = 1;
    localparam int KEY_LEFT  = 2;
    localparam int KEY_RIGHT = 3;
    localparam int KEY_SPACE = 4;
    localparam int KEY_R     = 5;
    localparam int KEY_PLUS  = 6;
    localparam int KEY_MINUS = 7;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_DELIVER = 1'b1
    } ksp_state_e;
endpackage

// File: rtl/ksp_decode.sv
module ksp_decode #(
    parameter int              SEL_W  = 8,
    parameter logic [SEL_W-1:0] DEV_ID = '0
) (
    input  logic [SEL_W-1:0] port_sel_i,
    input  logic             rd_stb_i,
    input  logic             wr_stb_i,
    output logic             rd_hit_o,
    output logic             wr_hit_o
);
    logic match;

    always_comb begin
        match    = (port_sel_i == DEV_ID);
        rd_hit_o = rd_stb_i & match;
        wr_hit_o = wr_stb_i & match;
    end
endmodule

// File: rtl/ksp_latch.sv
module ksp_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] key_i,
    input  logic         clr_i,
    output logic [W-1:0] state_q
);
    logic [W-1:0] state_d;

    // Per-bit sticky cell: a clear reloads from the live key, so a press
    // in the flush cycle survives it.
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            state_d[b] = clr_i ? key_i[b] : (state_q[b] | key_i[b]);
        end

        // R2: a held bit is kept while no clear arrives
        assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q[b] && !clr_i) |=> state_q[b]);

        // R2/R4: a pressed key is present on the next cycle, clear or not
        assert_press_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
            key_i[b] |=> state_q[b]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R3: after a clear only the keys of the clear cycle remain
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (state_q == $past(key_i)));
endmodule

// File: rtl/ksp_ctrl.sv
module ksp_ctrl
    import ksp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_hit_i,
    input  logic [W-1:0] snap_i,
    output logic         clr_o,
    output logic [W-1:0] rd_data_o
);
    ksp_state_e   state_q, state_d;
    logic [W-1:0] data_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = rd_hit_i ? ST_DELIVER : ST_IDLE;
            ST_DELIVER: state_d = rd_hit_i ? ST_DELIVER : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture register for the read result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        data_q <= '0;
        else if (rd_hit_i) data_q <= snap_i;
    end

    // Outputs
    always_comb begin
        clr_o = rd_hit_i;
        unique case (state_q)
            ST_DELIVER: rd_data_o = data_q;
            default:    rd_data_o = '0;
        endcase
    end

    // R3: an accepted read shows the earlier state byte one cycle later
    assert_read_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit_i |=> (rd_data_o == $past(snap_i)));

    // R8: the output is quiet after any cycle without an accepted read
    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit_i |=> (rd_data_o == '0));
endmodule

// File: rtl/keypad_port.sv
module keypad_port
    import ksp_pkg::*;
#(
    parameter int              SEL_W  = 8,
    parameter logic [SEL_W-1:0] DEV_ID = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key_i,
    input  logic [SEL_W-1:0] port_sel_i,
    input  logic             rd_stb_i,
    input  logic             wr_stb_i,
    output logic [KEY_W-1:0] rd_data_o
);
    logic             rd_hit, wr_hit, clr;
    logic [KEY_W-1:0] state;

    ksp_decode #(.SEL_W(SEL_W), .DEV_ID(DEV_ID)) u_dec (
        .port_sel_i (port_sel_i),
        .rd_stb_i   (rd_stb_i),
        .wr_stb_i   (wr_stb_i),
        .rd_hit_o   (rd_hit),
        .wr_hit_o   (wr_hit)
    );

    ksp_latch #(.W(KEY_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_i   (key_i),
        .clr_i   (clr),
        .state_q (state)
    );

    ksp_ctrl #(.W(KEY_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_hit_i  (rd_hit),
        .snap_i    (state),
        .clr_o     (clr),
        .rd_data_o (rd_data_o)
    );

    // R6: a write aimed at this device without a read leaves the output quiet
    assert_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !rd_hit) |=> (rd_data_o == '0));

    // R5: a read on another port leaves held bits in place
    assert_foreign_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && (port_sel_i != DEV_ID)) |=> (($past(state) & state) == $past(state)));
endmodule

// File: tb/tb_keypad_port.sv
module tb_keypad_port;
    localparam logic [7:0] DEV = 8'h05;

    typedef struct {
        logic [7:0] data;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] key_i = '0;
    logic [7:0] port_sel_i = '0;
    logic       rd_stb_i = 1'b0;
    logic       wr_stb_i = 1'b0;
    logic [7:0] rd_data_o;

    int   checks = 0;
    int   failures = 0;
    bit   mon_en = 1'b0;
    bit   done = 1'b0;
    exp_t sb[$];
    logic [7:0] model = '0;

    always #4 clk = ~clk;

    keypad_port #(.SEL_W(8), .DEV_ID(DEV)) dut (
        .clk(clk), .rst_n(rst_n), .key_i(key_i), .port_sel_i(port_sel_i),
        .rd_stb_i(rd_stb_i), .wr_stb_i(wr_stb_i), .rd_data_o(rd_data_o)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: rd_data_o=%02h expected %02h", req, got, exp);
        end
    endtask

    // Driver: one cycle of stimulus plus the expected output after its edge
    task automatic step(input logic [7:0] keys, input logic [7:0] port,
                        input bit rd, input bit wr, input string req);
        exp_t e;
        @(negedge clk);
        key_i = keys; port_sel_i = port; rd_stb_i = rd; wr_stb_i = wr;
        if (rd && port == DEV) begin
            e.data = model;
            model  = keys;
        end else begin
            e.data = 8'h00;
            model  = model | keys;
        end
        e.req = req;
        sb.push_back(e);
        mon_en = 1'b1;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(8'h00, 8'h00, 1'b0, 1'b0, req);
    endtask

    // Monitor: compares each cycle's output against the scoreboard
    always begin
        @(posedge clk);
        #2;
        if (mon_en && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(rd_data_o, e.data, e.req);
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: expired, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #3;
        check(rd_data_o, 8'h00, "R1 reset output");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1: first read returns an empty state
        step(8'h00, DEV, 1'b1, 1'b0, "R1 first read");
        idle(1, "R8 quiet");

        // R2: short press of up is held for several cycles
        step(8'h01, 8'h00, 1'b0, 1'b0, "R8 quiet");
        idle(4, "R2 held");
        step(8'h00, DEV, 1'b1, 1'b0, "R2 sticky up");
        idle(1, "R8 quiet");

        // R3: presses at different cycles accumulate
        step(8'h10, 8'h00, 1'b0, 1'b0, "R8 quiet");
        idle(2, "R8 quiet");
        step(8'h20, 8'h00, 1'b0, 1'b0, "R8 quiet");
        step(8'h00, DEV, 1'b1, 1'b0, "R3 accumulated");
        step(8'h00, DEV, 1'b1, 1'b0, "R3 cleared");

        // R5: read on another port neither clears nor drives
        step(8'h04, 8'h00, 1'b0, 1'b0, "R8 quiet");
        step(8'h00, 8'h06, 1'b1, 1'b0, "R5 foreign read output");
        step(8'h00, 8'h04, 1'b1, 1'b0, "R5 foreign read output");
        step(8'h00, DEV, 1'b1, 1'b0, "R5 state kept");

        // R6: writes, matching or not, change nothing
        step(8'h80, 8'h00, 1'b0, 1'b0, "R8 quiet");
        step(8'h00, DEV, 1'b0, 1'b1, "R6 write output");
        step(8'h00, 8'h09, 1'b0, 1'b1, "R6 write output");
        step(8'h00, DEV, 1'b1, 1'b0, "R6 state kept");
        idle(1, "R8 quiet");

        // R4/R8: key during read survives the clear; back-to-back reads
        step(8'h08, 8'h00, 1'b0, 1'b0, "R8 quiet");
        step(8'h40, DEV, 1'b1, 1'b0, "R4 excludes flush-cycle key");
        step(8'h02, DEV, 1'b1, 1'b0, "R4 flush-cycle key kept");
        step(8'h00, DEV, 1'b1, 1'b0, "R8 back-to-back");
        step(8'h00, DEV, 1'b1, 1'b0, "R8 empty read");

        // R7: every key maps to its own bit
        for (int b = 0; b < 8; b++) begin
            step(8'(1 << b), 8'h00, 1'b0, 1'b0, "R8 quiet");
            step(8'h00, DEV, 1'b1, 1'b0, "R7 bit map");
        end
        step(8'hFF, 8'h00, 1'b0, 1'b0, "R8 quiet");
        step(8'h00, DEV, 1'b1, 1'b0, "R7 all keys");
        idle(3, "R8 quiet");

        @(negedge clk);
        mon_en = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule